// File: doc/BRIEF.md
# UART Interrupt Priority and Identification Logic

This block gathers the interrupt conditions of a 16550-style serial port, masks each one with its enable bit and ranks what remains. The source that ranks highest appears in a byte-wide identification register, and a single interrupt line is raised whenever any enabled condition is pending. The status inputs come from the receive and transmit paths around it: receive error flags, the receive FIFO fill level against its trigger, a holding-buffer-full flag for non-FIFO operation, FIFO push and pop strobes, a one-per-character-time tick, the transmit FIFO level, a holding-register-taken pulse, and modem input change flags.

The host reaches the block through a simple byte port made of an address, read and write strobes, and write and read data. Register reads and writes at the usual offsets also serve as the clearing actions for the latched conditions. Reading the receive buffer, the line status or the modem status register clears the matching condition, and so does writing the transmit holding register. The block itself returns data only for the enable and identification registers. Every other read address returns zero.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Sources are ranked in four levels, from highest to lowest: line status, then receive data and receive timeout (which share level 2, with receive data reported first when both are pending), then transmit request, then modem status. Identification bits 3:1 show only the highest enabled pending source, encoded as line status 011, receive data 010, timeout 110, transmit 001 and modem 000.
- R2: Line status latches when any bit of `rx_err_bits` is set. A read of address 5 clears it. It is gated by enable bit 2.
- R3: In FIFO mode (`fifo_mode`=1), receive data is pending while `rx_fifo_level` >= `rx_trig_level`. In non-FIFO mode it is pending while `rx_hold_full` is 1. It clears when that condition goes away and is gated by enable bit 0.
- R4: Receive timeout can occur only in FIFO mode while the receive FIFO is non-empty. It latches on the TO_CHARS-th `char_tick` (default 4) that arrives with no push or pop. A read of address 0 clears it. It is gated by enable bit 0.
- R5: In FIFO mode the transmit request latches when the transmit FIFO level falls to FIFO_DEPTH/2 or below. In non-FIFO mode it latches on a `thr_taken` pulse. It is cleared by a write to address 0, or by a read of address 2 that returns the transmit code. It is gated by enable bit 1.
- R6: Modem status latches when any bit of `modem_delta` is set. A read of address 6 clears it. It is gated by enable bit 3. A condition latched while its enable bit is 0 becomes pending once the bit is set.
- R7: The identification register sits at address 2. Bit 0 is 1 when no interrupt is pending and 0 when one is, and bits 7:4 read 0. It resets to 0x01, and writes to it have no effect.
- R8: The enable register sits at address 1. Bits 3:0 are read/write and reset to 0, and bits 7:4 always read 0.
- R9: `irq` is 1 exactly when an enabled condition is pending. The identification value follows the current conditions combinationally, with no added cycle.
- R10: Any receive FIFO push or pop restarts the timeout count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1 selects FIFO operation |
| rx_err_bits | input | ERR_W | Receive error flags (overrun, parity, framing, break) |
| rx_hold_full | input | 1 | Non-FIFO receive buffer holds a character |
| rx_fifo_level | input | LVL_W | Receive FIFO fill level |
| rx_trig_level | input | LVL_W | Receive FIFO trigger level |
| rx_push | input | 1 | Receive FIFO push strobe |
| rx_pop | input | 1 | Receive FIFO pop strobe |
| char_tick | input | 1 | One pulse per character time |
| tx_fifo_level | input | LVL_W | Transmit FIFO fill level |
| thr_taken | input | 1 | Non-FIFO holding register moved to the shifter |
| modem_delta | input | MDM_W | Modem input change flags |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |

## Verification
A wrong latch, mask or priority shows up at once as a wrong identification byte and a wrong `irq` level. Because the identification value is combinational, the error is visible in the first cycle after the setting pulse is captured. A clear that fails to act leaves the old code visible on the very next read. A timeout counter that is off by one changes when the timeout code first appears by exactly one tick, so the bench checks the register one tick before and at the expected tick.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam logic [2:0] ID_LS = 3'b011;
  localparam logic [2:0] ID_RD = 3'b010;
  localparam logic [2:0] ID_TO = 3'b110;
  localparam logic [2:0] ID_TX = 3'b001;
  localparam logic [2:0] ID_MS = 3'b000;

  typedef struct packed {
    logic ls;
    logic rd;
    logic to;
    logic tx;
    logic ms;
  } irq_src_t;

  // apply enable bits: [0] rx data/timeout, [1] tx, [2] line status, [3] modem
  function automatic irq_src_t mask_src(irq_src_t raw, logic [3:0] en);
    irq_src_t m;
    m.ls = raw.ls & en[2];
    m.rd = raw.rd & en[0];
    m.to = raw.to & en[0];
    m.tx = raw.tx & en[1];
    m.ms = raw.ms & en[3];
    return m;
  endfunction

  function automatic logic [2:0] rank_id(irq_src_t m);
    if (m.ls)      return ID_LS;
    else if (m.rd) return ID_RD;
    else if (m.to) return ID_TO;
    else if (m.tx) return ID_TX;
    else           return ID_MS;
  endfunction

  function automatic logic any_src(irq_src_t m);
    return m.ls | m.rd | m.to | m.tx | m.ms;
  endfunction

endpackage

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
  parameter int LVL_W    = 5,
  parameter int TO_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             char_tick,
  input  logic             buf_rd,
  output logic             to_flag,
  output logic             to_fire
);

  localparam int CNT_W = $clog2(TO_CHARS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TO_CHARS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             armed;
  logic             activity;

  assign armed    = fifo_mode && (rx_level != '0) && !to_flag;
  assign activity = rx_push || rx_pop;
  assign to_fire  = armed && char_tick && !activity && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      to_flag <= 1'b0;
    end else begin
      if (buf_rd || !fifo_mode || rx_level == '0) to_flag <= 1'b0;
      else if (to_fire)                           to_flag <= 1'b1;

      if (activity || !armed) cnt_q <= '0;
      else if (char_tick)     cnt_q <= to_fire ? '0 : cnt_q + 1'b1;
    end
  end

  AST_TO_NEEDS_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_flag) |-> $past(fifo_mode && rx_level != '0)); // R4
  AST_TO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (activity && !to_flag) |=> !to_flag); // R10

endmodule

// File: rtl/uart_irq_flags.sv
module uart_irq_flags #(
  parameter int LVL_W      = 5,
  parameter int FIFO_DEPTH = 16,
  parameter int ERR_W      = 4,
  parameter int MDM_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic [ERR_W-1:0] rx_err_bits,
  input  logic             rx_hold_full,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             thr_taken,
  input  logic [MDM_W-1:0] modem_delta,
  input  logic             lsr_rd,
  input  logic             msr_rd,
  input  logic             thr_wr,
  input  logic             iir_tx_rd,
  output logic             ls_flag,
  output logic             rd_cond,
  output logic             tx_flag,
  output logic             ms_flag,
  output logic             tx_set
);

  localparam logic [LVL_W-1:0] TX_HALF = LVL_W'(FIFO_DEPTH / 2);

  logic ls_set;
  logic ms_set;
  logic tx_half;
  logic tx_half_q;
  logic tx_clr;

  assign ls_set  = |rx_err_bits;
  assign ms_set  = |modem_delta;
  assign tx_half = (tx_level <= TX_HALF);
  assign tx_set  = fifo_mode ? (tx_half && !tx_half_q) : thr_taken;
  assign tx_clr  = thr_wr || iir_tx_rd;
  assign rd_cond = fifo_mode ? (rx_level >= rx_trig) : rx_hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_flag   <= 1'b0;
      ms_flag   <= 1'b0;
      tx_flag   <= 1'b0;
      tx_half_q <= 1'b1;
    end else begin
      tx_half_q <= tx_half;
      if (ls_set)      ls_flag <= 1'b1;
      else if (lsr_rd) ls_flag <= 1'b0;
      if (ms_set)      ms_flag <= 1'b1;
      else if (msr_rd) ms_flag <= 1'b0;
      if (tx_set)      tx_flag <= 1'b1;
      else if (tx_clr) tx_flag <= 1'b0;
    end
  end

  AST_LS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !ls_set) |=> !ls_flag); // R2
  AST_MS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ms_set |=> ms_flag); // R6
  AST_TX_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !tx_set) |=> !tx_flag); // R5

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  irq_src_t   raw,
  input  logic [3:0] en,
  output logic [2:0] id,
  output logic       pending
);

  irq_src_t masked;

  assign masked  = mask_src(raw, en);
  assign id      = rank_id(masked);
  assign pending = any_src(masked);

  AST_LS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (raw.ls && en[2]) |-> (id == ID_LS)); // R1
  AST_RD_OVER_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (raw.rd && en[0] && !(raw.ls && en[2])) |-> (id == ID_RD)); // R1
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |-> (id == ID_MS)); // R7

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int TO_CHARS   = 4,
  parameter int ERR_W      = 4,
  parameter int MDM_W      = 4,
  parameter int ADDR_W     = 3,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode,
  input  logic [ERR_W-1:0]  rx_err_bits,
  input  logic              rx_hold_full,
  input  logic [LVL_W-1:0]  rx_fifo_level,
  input  logic [LVL_W-1:0]  rx_trig_level,
  input  logic              rx_push,
  input  logic              rx_pop,
  input  logic              char_tick,
  input  logic [LVL_W-1:0]  tx_fifo_level,
  input  logic              thr_taken,
  input  logic [MDM_W-1:0]  modem_delta,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_BUF = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_IER = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_IIR = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_LSR = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_MSR = ADDR_W'(6);

  logic [3:0] ier_q;
  logic       buf_rd, lsr_rd, msr_rd, iir_rd, thr_wr, iir_tx_rd;
  logic       ls_flag, rd_cond, tx_flag, ms_flag, to_flag;
  logic       to_fire, tx_set;
  logic [2:0] iir_id;
  logic       pending;
  irq_src_t   raw;
  logic       unused_wdata_hi;

  assign unused_wdata_hi = ^{reg_wdata[7:4], to_fire, tx_set};

  assign buf_rd    = reg_rd && (reg_addr == A_BUF);
  assign lsr_rd    = reg_rd && (reg_addr == A_LSR);
  assign msr_rd    = reg_rd && (reg_addr == A_MSR);
  assign iir_rd    = reg_rd && (reg_addr == A_IIR);
  assign thr_wr    = reg_wr && (reg_addr == A_BUF);
  assign iir_tx_rd = iir_rd && pending && (iir_id == ID_TX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            ier_q <= '0;
    else if (reg_wr && reg_addr == A_IER)  ier_q <= reg_wdata[3:0];
  end

  uart_irq_flags #(
    .LVL_W(LVL_W), .FIFO_DEPTH(FIFO_DEPTH), .ERR_W(ERR_W), .MDM_W(MDM_W)
  ) u_flags (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .rx_err_bits(rx_err_bits), .rx_hold_full(rx_hold_full),
    .rx_level(rx_fifo_level), .rx_trig(rx_trig_level),
    .tx_level(tx_fifo_level), .thr_taken(thr_taken),
    .modem_delta(modem_delta), .lsr_rd(lsr_rd), .msr_rd(msr_rd),
    .thr_wr(thr_wr), .iir_tx_rd(iir_tx_rd),
    .ls_flag(ls_flag), .rd_cond(rd_cond), .tx_flag(tx_flag),
    .ms_flag(ms_flag), .tx_set(tx_set)
  );

  uart_irq_timeout #(.LVL_W(LVL_W), .TO_CHARS(TO_CHARS)) u_timeout (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .rx_level(rx_fifo_level), .rx_push(rx_push), .rx_pop(rx_pop),
    .char_tick(char_tick), .buf_rd(buf_rd),
    .to_flag(to_flag), .to_fire(to_fire)
  );

  always_comb begin
    raw.ls = ls_flag;
    raw.rd = rd_cond;
    raw.to = to_flag;
    raw.tx = tx_flag;
    raw.ms = ms_flag;
  end

  uart_irq_prio u_prio (
    .clk(clk), .rst_n(rst_n), .raw(raw), .en(ier_q),
    .id(iir_id), .pending(pending)
  );

  assign irq = pending;

  always_comb begin
    case (reg_addr)
      A_IER:   reg_rdata = {4'b0000, ier_q};
      A_IIR:   reg_rdata = {4'b0000, iir_id, ~pending};
      default: reg_rdata = 8'h00;
    endcase
  end

  AST_IER_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_IER) |-> (reg_rdata[7:4] == 4'h0)); // R8
  AST_IIR_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_IIR) |=> $stable(ier_q)); // R7
  AST_TX_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_tx_rd && !tx_set) |=> !tx_flag); // R5

endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;

  localparam int LVL_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             fifo_mode = 1'b0;
  logic [3:0]       rx_err_bits = '0;
  logic             rx_hold_full = 1'b0;
  logic [LVL_W-1:0] rx_fifo_level = '0;
  logic [LVL_W-1:0] rx_trig_level = 5'd8;
  logic             rx_push = 1'b0;
  logic             rx_pop = 1'b0;
  logic             char_tick = 1'b0;
  logic [LVL_W-1:0] tx_fifo_level = '0;
  logic             thr_taken = 1'b0;
  logic [3:0]       modem_delta = '0;
  logic [2:0]       reg_addr = '0;
  logic             reg_wr = 1'b0;
  logic             reg_rd = 1'b0;
  logic [7:0]       reg_wdata = '0;
  logic [7:0]       reg_rdata;
  logic             irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .rx_err_bits(rx_err_bits), .rx_hold_full(rx_hold_full),
    .rx_fifo_level(rx_fifo_level), .rx_trig_level(rx_trig_level),
    .rx_push(rx_push), .rx_pop(rx_pop), .char_tick(char_tick),
    .tx_fifo_level(tx_fifo_level), .thr_taken(thr_taken),
    .modem_delta(modem_delta), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  // {ier[3:0], err, hold, thr, mdm, expected iir[3:0]}
  localparam int NV = 12;
  localparam logic [11:0] VEC [NV] = '{
    {4'hF, 4'b1111, 4'b0110},
    {4'hF, 4'b0111, 4'b0100},
    {4'hF, 4'b0011, 4'b0010},
    {4'hF, 4'b0001, 4'b0000},
    {4'h0, 4'b1111, 4'b0001},
    {4'hB, 4'b1111, 4'b0100},
    {4'h8, 4'b1001, 4'b0000},
    {4'h2, 4'b0010, 4'b0010},
    {4'h4, 4'b1100, 4'b0110},
    {4'h1, 4'b0011, 4'b0001},
    {4'hE, 4'b0110, 4'b0010},
    {4'h0, 4'b0000, 4'b0001}
  };

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d, output logic q);
    reg_addr = a; reg_rd = 1'b1;
    #1;
    d = reg_rdata; q = irq;
    step();
    reg_rd = 1'b0;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      char_tick = 1'b1; step(); char_tick = 1'b0; step();
    end
  endtask

  task automatic chk_iir(string req, logic [7:0] exp);
    logic [7:0] d;
    logic q;
    rd(3'd2, d, q);
    check(req, d, exp);
    check(req, {7'd0, q}, {7'd0, ~exp[0]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic q;
    @(negedge clk); @(negedge clk);
    // reset state: R7 R8 R9
    #1 check("R9 irq at reset", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk_iir("R7 iir reset", 8'h01);
    rd(3'd1, d, q); check("R8 ier reset", d, 8'h00);

    // vector walk: R1 R2 R3 R5 R6 R9 in non-FIFO mode
    for (int v = 0; v < NV; v++) begin
      rx_hold_full = 1'b0;
      rd(3'd5, d, q); rd(3'd6, d, q); wr(3'd0, 8'h00);
      wr(3'd1, {4'h0, VEC[v][11:8]});
      rx_err_bits = {3'b000, VEC[v][7]};
      thr_taken   = VEC[v][5];
      modem_delta = {VEC[v][4], 3'b000};
      rx_hold_full = VEC[v][6];
      step();
      rx_err_bits = '0; thr_taken = 1'b0; modem_delta = '0;
      chk_iir($sformatf("R1 vector %0d", v), {4'h0, VEC[v][3:0]});
    end
    rx_hold_full = 1'b0;
    rd(3'd5, d, q); rd(3'd6, d, q); wr(3'd0, 8'h00);

    // R8 reserved bits and R7 read-only
    wr(3'd1, 8'hF0); rd(3'd1, d, q); check("R8 ier reserved", d, 8'h00);
    wr(3'd1, 8'hFF); rd(3'd1, d, q); check("R8 ier readback", d, 8'h0F);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h00); chk_iir("R7 iir write ignored", 8'h01);

    // R6 latent modem change then enable
    modem_delta = 4'b0100; step(); modem_delta = '0;
    chk_iir("R6 masked modem", 8'h01);
    wr(3'd1, 8'h08); chk_iir("R6 enable exposes modem", 8'h00);
    rd(3'd6, d, q); chk_iir("R6 msr read clears", 8'h01);

    // R2 line status clear
    wr(3'd1, 8'h04);
    rx_err_bits = 4'b1000; step(); rx_err_bits = '0;
    chk_iir("R2 line status", 8'h06);
    rd(3'd5, d, q); chk_iir("R2 lsr read clears", 8'h01);

    // R5 identification read clears transmit
    wr(3'd1, 8'h02);
    thr_taken = 1'b1; step(); thr_taken = 1'b0;
    chk_iir("R5 tx shown", 8'h02);
    chk_iir("R5 iir read cleared tx", 8'h01);

    // R3 FIFO trigger
    fifo_mode = 1'b1; wr(3'd1, 8'h01);
    rx_fifo_level = 5'd7; step(); chk_iir("R3 below trigger", 8'h01);
    rx_fifo_level = 5'd8; step(); chk_iir("R3 at trigger", 8'h04);
    rx_fifo_level = 5'd7; step(); chk_iir("R3 drained below", 8'h01);

    // R4 timeout
    rx_fifo_level = 5'd2; step();
    tick(3); chk_iir("R4 no timeout at 3 ticks", 8'h01);
    tick(1); chk_iir("R4 timeout at 4 ticks", 8'h0C);
    rd(3'd0, d, q); chk_iir("R4 buffer read clears", 8'h01);

    // R10 restart on push
    tick(3);
    rx_push = 1'b1; step(); rx_push = 1'b0;
    tick(3); chk_iir("R10 push restarts count", 8'h01);
    tick(1); chk_iir("R10 timeout after restart", 8'h0C);
    rd(3'd0, d, q);

    // R1 receive data outranks timeout
    tick(4); rx_fifo_level = 5'd9; step();
    chk_iir("R1 rx data over timeout", 8'h04);
    rd(3'd0, d, q); rx_fifo_level = 5'd0; step();

    // R4 no timeout in non-FIFO mode
    fifo_mode = 1'b0; rx_fifo_level = 5'd3; step();
    tick(6); chk_iir("R4 none in non-FIFO", 8'h01);
    rx_fifo_level = 5'd0;

    // R5 FIFO half-empty request
    fifo_mode = 1'b1; wr(3'd1, 8'h02);
    tx_fifo_level = 5'd16; step();
    tx_fifo_level = 5'd9; step(); chk_iir("R5 above half", 8'h01);
    tx_fifo_level = 5'd8; step(); chk_iir("R5 half empty", 8'h02);
    wr(3'd0, 8'h55); chk_iir("R5 thr write clears", 8'h01);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule